// File: doc/BRIEF.md
# Dual-Clock Word RAM with Switchable Read Path

This block is a 2,304-bit on-chip memory with one port that only writes and one port that only reads. Each port has its own clock. A write stores one word on a rising edge of the write clock while the write enable is high. The read port can be switched by a mode pin between two behaviours:

- a registered output, which captures the addressed word on a read-clock edge and is gated by the read enable;
- a flow-through output, which shows the addressed word without any clock while the read enable is high.

A static 2-bit shape input divides the fixed storage into words of 18, 9, 4 or 2 bits, with a matching depth. Address and data lines above the selected shape are not used.

Both ports are plain, enable-qualified memory ports and never stall. Each enable acts as a valid strobe that the block always accepts in the same cycle. There is therefore no ready signal and no back-pressure. The shape input may change only while `rst_n` is low. Only the read output register is cleared by reset; the storage contents start out undefined.

Top module: `dual_clock_ram`

## Requirements
- R1: While `rst_n` is low, and after its release until the first read capture, `rdata` is all zeros in registered mode.
- R2: On a `wclk` rising edge with `we` high, the word on `wdata` is stored at `waddr`. With `we` low, the stored contents do not change.
- R3: In registered mode (`async_rd`=0), `rdata` takes the word at `raddr` on a `rclk` rising edge only when `re` is high. With `re` low, `rdata` holds its value.
- R4: In flow-through mode (`async_rd`=1) with `re` high, `rdata` shows the word at `raddr` combinationally and follows changes of `raddr` without a clock edge.
- R5: In flow-through mode with `re` low, `rdata` holds the word that was captured at the most recent `rclk` edge at which `re` was high.
- R6: `width_cfg` sets the shape. Value 0 gives 128 words of 18 bits, 1 gives 256x9, 2 gives 512x4 and 3 gives 1024x2. The word width is 18 shifted right by `width_cfg`. Bits of `wdata` above the word width are ignored, and bits of `rdata` above the word width read as zero.
- R7: Address bits at position 7+`width_cfg` and above are ignored. Words that share a physical row never disturb one another when either of them is written. Within a row, the low `width_cfg` address bits pick the lane, starting from bit 0.
- R8: When a write and a read hit the same word on the same clock edge, a registered read returns the old contents. A flow-through read shows the new contents once that edge has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-port clock |
| we | input | 1 | Write enable, acts as a clock enable |
| waddr | input | 10 | Write word address |
| wdata | input | 18 | Write data, low word-width bits used |
| rclk | input | 1 | Read-port clock |
| rst_n | input | 1 | Active-low reset of the read output register, asynchronous assert |
| re | input | 1 | Read enable: clock enable (registered) or pass gate (flow-through) |
| raddr | input | 10 | Read word address |
| rdata | output | 18 | Read data, zero above word width |
| async_rd | input | 1 | 1 selects flow-through read, 0 selects registered read |
| width_cfg | input | 2 | Static word shape select |

## Verification
The bench ties both clocks together so that a write and a read can land on the same word at the same edge. It does this in every shape and in both read modes. A registered collision is judged by whether the captured value is the old word. A flow-through collision is judged first before the edge, where the old word is expected, and again after it, where the new word is expected. A behavioural word-level model predicts `rdata` every cycle. Writes with random junk in the upper address and data bits check that neighbouring lanes of a row stay untouched when their row is rewritten.

// File: rtl/dpr_pkg.sv
`timescale 1ns/1ps
package dpr_pkg;

  // Word shape: word width is DATA_W >> shape, depth is ROWS << shape.
  typedef enum logic [1:0] {
    SHAPE_FULL    = 2'd0,
    SHAPE_HALF    = 2'd1,
    SHAPE_QUARTER = 2'd2,
    SHAPE_EIGHTH  = 2'd3
  } shape_e;

  localparam int unsigned NUM_SHAPES = 4;
  localparam int unsigned LANE_SEL_W = NUM_SHAPES - 1;

  function automatic int unsigned lane_bits(input int unsigned data_w, input shape_e shape);
    return data_w >> shape;
  endfunction

endpackage

// File: rtl/dpr_lane_map.sv
`timescale 1ns/1ps
// Splits a word address into a physical row and a bit lane for the current shape.
module dpr_lane_map
  import dpr_pkg::*;
#(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned ROW_AW = 7,
  localparam int unsigned OFF_W = $clog2(DATA_W + 1)
) (
  input  shape_e              shape,
  input  logic [ADDR_W-1:0]   addr,
  output logic [ROW_AW-1:0]   row,
  output logic [OFF_W-1:0]    offset,
  output logic [DATA_W-1:0]   base_mask
);

  logic [LANE_SEL_W-1:0] lane;
  logic [OFF_W-1:0]      width;

  always_comb begin
    width  = OFF_W'(lane_bits(DATA_W, shape));
    lane   = addr[LANE_SEL_W-1:0] & ((LANE_SEL_W'(1) << shape) - LANE_SEL_W'(1));
    row    = ROW_AW'(addr >> shape);
    offset = OFF_W'(int'(lane) * int'(width));
    if (int'(width) >= int'(DATA_W))
      base_mask = '1;
    else
      base_mask = (DATA_W'(1) << width) - DATA_W'(1);
  end

  always_comb begin
    AST_LANE_FIT: assert (int'(offset) + int'(width) <= int'(DATA_W)) // R7
      else $error("AST_LANE_FIT");
  end

endmodule

// File: rtl/dpr_store.sv
`timescale 1ns/1ps
// Row storage with per-bit masked write; read side is combinational.
module dpr_store #(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned ROWS   = 128,
  localparam int unsigned ROW_AW = $clog2(ROWS)
) (
  input  logic              wclk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ROW_AW-1:0] wrow,
  input  logic [DATA_W-1:0] wmask,
  input  logic [DATA_W-1:0] wbits,
  input  logic [ROW_AW-1:0] rrow,
  output logic [DATA_W-1:0] rrow_data
);

  logic [DATA_W-1:0] cells [ROWS];

  always_ff @(posedge wclk) begin
    if (we)
      cells[wrow] <= (cells[wrow] & ~wmask) | (wbits & wmask);
  end

  assign rrow_data = cells[rrow];

  AST_WRITE_LANDS: assert property (@(posedge wclk) disable iff (!rst_n)
    we |=> (((cells[$past(wrow)] ^ $past(wbits)) & $past(wmask)) == '0)) // R2
    else $error("AST_WRITE_LANDS");

  AST_NEIGHBOURS_KEPT: assert property (@(posedge wclk) disable iff (!rst_n)
    we |=> (((cells[$past(wrow)] ^ $past(cells[wrow])) & ~$past(wmask)) == '0)) // R7
    else $error("AST_NEIGHBOURS_KEPT");

endmodule

// File: rtl/dpr_read_port.sv
`timescale 1ns/1ps
// Lane extraction, output register and flow-through bypass.
module dpr_read_port #(
  parameter int unsigned DATA_W = 18,
  localparam int unsigned OFF_W = $clog2(DATA_W + 1)
) (
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              async_rd,
  input  logic              re,
  input  logic [DATA_W-1:0] row_data,
  input  logic [OFF_W-1:0]  offset,
  input  logic [DATA_W-1:0] base_mask,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] word;
  logic [DATA_W-1:0] hold_q;

  assign word = (row_data >> offset) & base_mask;

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n)
      hold_q <= '0;
    else if (re)
      hold_q <= word;
  end

  assign rdata = (async_rd && re) ? word : hold_q;

  AST_SYNC_CAPTURE: assert property (@(posedge rclk) disable iff (!rst_n)
    (!async_rd && re) |=> ((async_rd && re) || rdata == $past(word))) // R3
    else $error("AST_SYNC_CAPTURE");

  AST_IDLE_HOLD: assert property (@(posedge rclk) disable iff (!rst_n)
    !re |=> ((async_rd && re) || $stable(rdata))) // R5
    else $error("AST_IDLE_HOLD");

  AST_UPPER_ZERO: assert property (@(posedge rclk) disable iff (!rst_n)
    (rdata & ~base_mask) == '0) // R6
    else $error("AST_UPPER_ZERO");

endmodule

// File: rtl/dual_clock_ram.sv
`timescale 1ns/1ps
module dual_clock_ram
  import dpr_pkg::*;
#(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned ROWS   = 128
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata,
  input  logic              async_rd,
  input  logic [1:0]        width_cfg
);

  localparam int unsigned ROW_AW = $clog2(ROWS);
  localparam int unsigned OFF_W  = $clog2(DATA_W + 1);

  shape_e shape;
  assign shape = shape_e'(width_cfg);

  logic [ROW_AW-1:0] wrow, rrow;
  logic [OFF_W-1:0]  woff, roff;
  logic [DATA_W-1:0] wbase, rbase, wmask, wbits, row_data;

  dpr_lane_map #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .ROW_AW(ROW_AW)) i_wmap (
    .shape(shape), .addr(waddr), .row(wrow), .offset(woff), .base_mask(wbase)
  );

  dpr_lane_map #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .ROW_AW(ROW_AW)) i_rmap (
    .shape(shape), .addr(raddr), .row(rrow), .offset(roff), .base_mask(rbase)
  );

  assign wmask = wbase << woff;
  assign wbits = (wdata & wbase) << woff;

  dpr_store #(.DATA_W(DATA_W), .ROWS(ROWS)) i_store (
    .wclk(wclk), .rst_n(rst_n), .we(we), .wrow(wrow), .wmask(wmask),
    .wbits(wbits), .rrow(rrow), .rrow_data(row_data)
  );

  dpr_read_port #(.DATA_W(DATA_W)) i_rport (
    .rclk(rclk), .rst_n(rst_n), .async_rd(async_rd), .re(re),
    .row_data(row_data), .offset(roff), .base_mask(rbase), .rdata(rdata)
  );

  AST_CFG_STATIC: assert property (@(posedge rclk) disable iff (!rst_n)
    1'b1 |=> $stable(width_cfg)) // R6
    else $error("AST_CFG_STATIC");

endmodule

// File: tb/test_dual_clock_ram.sv
`timescale 1ns/1ps
module test_dual_clock_ram;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0, async_rd = 1'b0;
  logic [9:0]  waddr = '0, raddr = '0;
  logic [17:0] wdata = '0;
  logic [1:0]  width_cfg = 2'd0;
  logic [17:0] rdata;

  always #2.5 clk = ~clk;

  dual_clock_ram i_dual_clock_ram (
    .wclk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .rclk(clk), .rst_n(rst_n), .re(re), .raddr(raddr), .rdata(rdata),
    .async_rd(async_rd), .width_cfg(width_cfg)
  );

  int checks = 0, failures = 0;
  bit done = 0;

  // Behavioural word-level model
  logic [17:0] mdl [1024];
  logic [17:0] hold_m = '0;
  int depth = 128, lmask = 18'h3ffff;

  function automatic logic [17:0] model_rd(input logic [9:0] a);
    return mdl[int'(a) % depth];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) hold_m = '0;
    else begin
      logic [17:0] old;
      old = model_rd(raddr);
      if (we) mdl[int'(waddr) % depth] = wdata & 18'(lmask);
      if (re) hold_m = old;
    end
  end

  task automatic check(input string tag, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: rdata=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic w_en, input logic [9:0] wa, input logic [17:0] wd,
                      input logic r_en, input logic [9:0] ra, input string tag);
    @(negedge clk);
    we = w_en; waddr = wa; wdata = wd; re = r_en; raddr = ra;
    #1;
    if (rst_n) check(tag, rdata, (async_rd && re) ? model_rd(ra) : hold_m);
  endtask

  function automatic logic [9:0] junk_addr(input int a, input int m);
    return 10'((a % (128 << m)) + (($urandom % 8) << (7 + m)));
  endfunction

  initial begin
    for (int m = 0; m < 4; m++) begin
      // reset and shape change (R1, R6)
      @(negedge clk);
      rst_n = 1'b0; width_cfg = 2'(m); async_rd = 1'b0;
      we = 1'b0; re = 1'b0;
      depth = 128 << m;
      lmask = (1 << (18 >> m)) - 1;
      repeat (3) @(posedge clk);
      @(negedge clk); #1;
      check("R1 in reset", rdata, 18'h0);
      rst_n = 1'b1;
      step(0, 0, 0, 0, 10'h3ff, "R1 after release");
      step(0, 0, 0, 0, 10'h155, "R1 after release");

      // fill every word with junk in upper address and data bits (R2, R6, R7)
      for (int a = 0; a < depth; a++)
        step(1, junk_addr(a, m), 18'($urandom), 0, 0, "R2");
      // read back all words registered (R6 R7: neighbours and upper-bit zeroing)
      for (int a = 0; a < depth; a++)
        step(0, 0, 0, 1, junk_addr(a, m), (m == 0) ? "R7" : "R6");
      step(0, 0, 0, 0, 0, "R6");

      // disabled writes must not alter contents (R2)
      for (int i = 0; i < 40; i++)
        step(0, 10'($urandom), 18'($urandom), 1, 10'($urandom), "R2");

      // registered mode, mixed traffic (R3)
      for (int i = 0; i < 200; i++)
        step(1'($urandom), 10'($urandom), 18'($urandom), 1'($urandom),
             10'($urandom), "R3");

      // registered collision (R8)
      for (int i = 0; i < 8; i++) begin
        logic [9:0] a;
        a = 10'($urandom);
        step(1, a, 18'($urandom), 1, a, "R8");
        step(0, 0, 0, 0, a, "R8");
      end

      // flow-through mode (R4, R5)
      @(negedge clk); async_rd = 1'b1;
      for (int i = 0; i < 60; i++)
        step(0, 0, 0, 1, 10'($urandom), "R4");
      for (int i = 0; i < 60; i++)
        step(1'($urandom), 10'($urandom), 18'($urandom), 1'($urandom),
             10'($urandom), (i % 2 == 0) ? "R4" : "R5");
      step(0, 0, 0, 1, 10'h0aa, "R4");
      for (int i = 0; i < 20; i++)
        step(0, 0, 0, 0, 10'($urandom), "R5");

      // flow-through collision: old before the edge, new after (R8)
      for (int i = 0; i < 8; i++) begin
        logic [9:0] a;
        a = 10'($urandom);
        step(1, a, 18'($urandom), 1, a, "R8");
        step(0, 0, 0, 1, a, "R8");
      end
      @(negedge clk); async_rd = 1'b0;
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule